// File: doc/BRIEF.md
# Multi-mode 16-bit timer/counter

This block is a 16-bit down-counter paired with a 16-bit companion register. The companion register serves either as the reload value or as the capture target, depending on the mode. Software reaches both through byte-wide registers. A small control byte selects one of the following behaviours:

- a free-running timer that steps on an instruction-cycle tick and reloads from the companion register when it underflows;
- the same timer, also driving a square wave on the shared event pin;
- an event counter that steps on a chosen edge of that pin;
- a timer that latches its current count into the companion register on a chosen pin edge.

Each hardware event sets a sticky pending bit. A per-source enable turns a pending bit into an interrupt request. The event pin is resynchronised with two flops before its edges are detected. The tick input is a single-cycle enable that the surrounding core provides once per instruction cycle.

Top module: `mtimer`

## Requirements
- R1: After reset, every readable register (count, companion, control, flags) reads 0x00, and `irq`, `tio_out` and `tio_oe` are all 0.
- R2: In mode 100 with run set, the count drops by one on each cycle in which `tick` is high, and it does not change in cycles without `tick`.
- R3: In modes 000, 001, 100 and 101, a count step taken while the count is 0x0000 loads the companion value instead of wrapping, and sets the underflow pending bit (flags bit 0).
- R4: With run clear, neither the count nor the companion register changes, whatever `tick` or the pin does.
- R5: `tio_oe` is 1 only while the mode is 101. In that mode, `tio_out` inverts on every underflow, and it changes at no other time.
- R6: Mode 000 steps the count on each rising edge of `tio_in`, and mode 001 on each falling edge. In both modes, `tick` and the opposite edge have no effect.
- R7: Mode 110 (rising edge) and mode 111 (falling edge) copy the count into the companion register on the selected edge of `tio_in`, and set the capture pending bit (flags bit 1). The opposite edge is ignored. In these modes the count steps on `tick`, wraps from 0x0000 to 0xFFFF with no reload, and never sets the underflow bit.
- R8: Modes 010 and 011 are illegal. In them the count and companion register hold, and no pending bit is set.
- R9: Pending bits are sticky. Writing the flags register with a 1 in a bit position clears that bit, and writing a 0 leaves it unchanged. `irq` is high when (flags bit 0 AND ctrl bit 4) OR (flags bit 1 AND ctrl bit 5).
- R10: The address map is as follows: 0 = count low byte, 1 = count high byte, 2 = companion low byte, 3 = companion high byte, 4 = control, 5 = flags. Other addresses read 0x00. A byte write changes only its own byte.
- R11: The control byte holds the mode in bits 2:0, run in bit 3, the underflow enable in bit 4 and the capture enable in bit 5. It reads back as written, with bits 7:6 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick | input | 1 | Instruction-cycle step enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 8 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 8 | Register read data (combinational) |
| tio_in | input | 1 | Event pin input, asynchronous |
| tio_out | output | 1 | Event pin output value |
| tio_oe | output | 1 | Event pin output enable |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are those where a pin edge must land while the counter holds a particular value. Examples are an underflow driven by an external edge, and a capture taken just after the count has wrapped past zero.

Because of the two-flop synchroniser, an edge takes effect three clocks after the pin moves. The stimulus therefore loads the count through the byte registers before setting run. It then changes the pin only during windows with no tick, and waits out the synchroniser before reading back. This way each edge meets a known count.

The same sequence, repeated with opposite edges and the illegal encodings, shows which edges and modes leave the registers untouched.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

    localparam int BYTE_W = 8;
    localparam int NSRC   = 2;   // pending sources: 0 underflow, 1 capture

    typedef enum logic [2:0] {
        MODE_CNT_RISE = 3'b000,
        MODE_CNT_FALL = 3'b001,
        MODE_BAD_A    = 3'b010,
        MODE_BAD_B    = 3'b011,
        MODE_TIMER    = 3'b100,
        MODE_TOGGLE   = 3'b101,
        MODE_CAP_RISE = 3'b110,
        MODE_CAP_FALL = 3'b111
    } mode_e;

    typedef struct packed {
        logic  ie_cap;
        logic  ie_uf;
        logic  run;
        mode_e mode;
    } ctrl_t;

    function automatic logic mode_legal(mode_e m);
        return !(m == MODE_BAD_A || m == MODE_BAD_B);
    endfunction

    function automatic logic mode_capture(mode_e m);
        return (m == MODE_CAP_RISE || m == MODE_CAP_FALL);
    endfunction

    function automatic logic mode_external(mode_e m);
        return (m == MODE_CNT_RISE || m == MODE_CNT_FALL);
    endfunction

endpackage

// File: rtl/mtimer_edge.sv
module mtimer_edge #(
    parameter int SYNC = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [SYNC:0] pipe;   // SYNC resync stages plus one history stage
    } edge_s;

    edge_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pipe = {st_q.pipe[SYNC-1:0], pin};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rise = st_q.pipe[SYNC-1] & ~st_q.pipe[SYNC];
    assign fall = ~st_q.pipe[SYNC-1] & st_q.pipe[SYNC];
endmodule

// File: rtl/mtimer_core.sv
module mtimer_core
    import mtimer_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      rise,
    input  logic                      fall,
    input  ctrl_t                     ctrl,
    input  logic [WIDTH/BYTE_W-1:0]   cnt_we,
    input  logic [WIDTH/BYTE_W-1:0]   rld_we,
    input  logic [BYTE_W-1:0]         wdata,
    output logic [WIDTH-1:0]          cnt,
    output logic [WIDTH-1:0]          rld,
    output logic                      uf_evt,
    output logic                      cap_evt
);
    localparam int NB = WIDTH / BYTE_W;

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
        logic [WIDTH-1:0] rld;
    } core_s;

    core_s st_d, st_q;
    logic  uf_c, cap_c, step_c, edge_c;

    always_comb begin
        st_d   = st_q;
        uf_c   = 1'b0;
        cap_c  = 1'b0;
        step_c = 1'b0;
        edge_c = (ctrl.mode == MODE_CNT_RISE || ctrl.mode == MODE_CAP_RISE) ? rise : fall;

        if (ctrl.run && mode_legal(ctrl.mode)) begin
            if (mode_capture(ctrl.mode)) begin
                if (edge_c) begin
                    st_d.rld = st_q.cnt;
                    cap_c    = 1'b1;
                end
                if (tick) st_d.cnt = st_q.cnt - 1'b1;
            end else begin
                step_c = mode_external(ctrl.mode) ? edge_c : tick;
                if (step_c) begin
                    if (st_q.cnt == '0) begin
                        st_d.cnt = st_q.rld;
                        uf_c     = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - 1'b1;
                    end
                end
            end
        end

        // software byte writes take priority over hardware updates
        for (int i = 0; i < NB; i++) begin
            if (cnt_we[i]) st_d.cnt[i*BYTE_W +: BYTE_W] = wdata;
            if (rld_we[i]) st_d.rld[i*BYTE_W +: BYTE_W] = wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt     = st_q.cnt;
    assign rld     = st_q.rld;
    assign uf_evt  = uf_c;
    assign cap_evt = cap_c;
endmodule

// File: rtl/mtimer_tio.sv
module mtimer_tio
    import mtimer_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  mode_e mode,
    input  logic  uf_evt,
    output logic  tio_out,
    output logic  tio_oe
);
    typedef struct packed {
        logic level;
    } tio_s;

    tio_s st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (uf_evt && mode == MODE_TOGGLE) st_d.level = ~st_q.level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tio_out = st_q.level;
    assign tio_oe  = (mode == MODE_TOGGLE);
endmodule

// File: rtl/mtimer_irq.sv
module mtimer_irq #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] en,
    output logic [N-1:0] pend,
    output logic         irq
);
    typedef struct packed {
        logic [N-1:0] pend;
    } irq_s;

    irq_s st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.pend = (st_q.pend & ~clr) | set;   // a new event wins over a clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pend = st_q.pend;
    assign irq  = |(st_q.pend & en);
endmodule

// File: rtl/mtimer.sv
module mtimer
    import mtimer_pkg::*;
#(
    parameter int WIDTH  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    input  logic              tio_in,
    output logic              tio_out,
    output logic              tio_oe,
    output logic              irq
);
    localparam int NB = WIDTH / BYTE_W;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(2 * NB);
    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(2 * NB + 1);

    typedef struct packed {
        ctrl_t ctrl;
    } top_s;

    top_s st_d, st_q;

    logic [NB-1:0]    cnt_we, rld_we;
    logic [NSRC-1:0]  clr, pend, set_v, en_v;
    logic [WIDTH-1:0] cnt_val, rld_val;
    logic             rise, fall, uf_evt, cap_evt;
    logic [2:0]       mode;
    logic             run;

    always_comb begin
        st_d = st_q;
        if (wr_en && wr_addr == CTRL_ADDR) st_d.ctrl = ctrl_t'(wr_data[5:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            cnt_we[i] = wr_en && (wr_addr == ADDR_W'(i));
            rld_we[i] = wr_en && (wr_addr == ADDR_W'(NB + i));
        end
        clr = (wr_en && wr_addr == FLAG_ADDR) ? wr_data[NSRC-1:0] : '0;
    end

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NB; i++) begin
            if (rd_addr == ADDR_W'(i))      rd_data = cnt_val[i*BYTE_W +: BYTE_W];
            if (rd_addr == ADDR_W'(NB + i)) rd_data = rld_val[i*BYTE_W +: BYTE_W];
        end
        if (rd_addr == CTRL_ADDR) rd_data = {2'b00, st_q.ctrl};
        if (rd_addr == FLAG_ADDR) rd_data = {{(8 - NSRC){1'b0}}, pend};
    end

    assign mode  = st_q.ctrl.mode;
    assign run   = st_q.ctrl.run;
    assign set_v = {cap_evt, uf_evt};
    assign en_v  = {st_q.ctrl.ie_cap, st_q.ctrl.ie_uf};

    mtimer_edge #(.SYNC(2)) u_edge (
        .clk(clk), .rst_n(rst_n), .pin(tio_in), .rise(rise), .fall(fall)
    );

    mtimer_core #(.WIDTH(WIDTH)) u_core (
        .clk(clk), .rst_n(rst_n), .tick(tick), .rise(rise), .fall(fall),
        .ctrl(st_q.ctrl), .cnt_we(cnt_we), .rld_we(rld_we), .wdata(wr_data),
        .cnt(cnt_val), .rld(rld_val), .uf_evt(uf_evt), .cap_evt(cap_evt)
    );

    mtimer_tio u_tio (
        .clk(clk), .rst_n(rst_n), .mode(st_q.ctrl.mode), .uf_evt(uf_evt),
        .tio_out(tio_out), .tio_oe(tio_oe)
    );

    mtimer_irq #(.N(NSRC)) u_irq (
        .clk(clk), .rst_n(rst_n), .set(set_v), .clr(clr), .en(en_v),
        .pend(pend), .irq(irq)
    );
endmodule

// File: rtl/mtimer_chk.sv
module mtimer_chk #(
    parameter int WIDTH  = 16,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [7:0]        wr_data,
    input logic [2:0]        mode,
    input logic              run,
    input logic [WIDTH-1:0]  cnt_val,
    input logic [WIDTH-1:0]  rld_val,
    input logic              uf_evt,
    input logic              cap_evt,
    input logic [1:0]        pend,
    input logic              tio_out
);
    localparam logic [ADDR_W-1:0] FLAG_ADDR = ADDR_W'(2 * (WIDTH / 8) + 1);

    // R3
    reload_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt && !wr_en |=> cnt_val == $past(rld_val));

    // R3
    underflow_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        uf_evt |=> pend[0]);

    // R4
    stopped_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run && !wr_en |=> $stable(cnt_val) && $stable(rld_val));

    // R5
    toggle_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tio_out) |-> $past(mode == 3'b101));

    // R7
    capture_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_evt && !wr_en |=> rld_val == $past(cnt_val));

    // R8
    illegal_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 3'b010 || mode == 3'b011) && !wr_en |=> $stable(cnt_val));

    // R9
    pending_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend[0]) |-> $past(wr_en && wr_addr == FLAG_ADDR && wr_data[0]));
endmodule

bind mtimer mtimer_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .mode(mode), .run(run), .cnt_val(cnt_val), .rld_val(rld_val),
    .uf_evt(uf_evt), .cap_evt(cap_evt), .pend(pend), .tio_out(tio_out)
);

// File: tb/mtimer_test.sv
module mtimer_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic [2:0] rd_addr = '0;
    logic [7:0] rd_data;
    logic       tio_in = 1'b0;
    logic       tio_out, tio_oe, irq;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;   // 250 MHz

    mtimer uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .tio_in(tio_in),
        .tio_out(tio_out), .tio_oe(tio_oe), .irq(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        rd_addr = a;
        #1 d = rd_data;
    endtask

    task automatic rd16(input logic [2:0] a, output logic [15:0] v);
        logic [7:0] lo, hi;
        rd(a, lo);
        rd(a + 3'd1, hi);
        v = {hi, lo};
    endtask

    task automatic wr16(input logic [2:0] a, input logic [15:0] v);
        wr(a, v[7:0]);
        wr(a + 3'd1, v[15:8]);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); tick = 1'b1;
            @(negedge clk); tick = 1'b0;
        end
    endtask

    task automatic pin(input logic v);
        @(negedge clk); tio_in = v;
        repeat (5) @(negedge clk);
    endtask

    task automatic check_cnt(input string req, input logic [15:0] exp);
        logic [15:0] v;
        rd16(3'd0, v);
        chk(req, {16'h0, v}, {16'h0, exp});
    endtask

    task automatic check_rld(input string req, input logic [15:0] exp);
        logic [15:0] v;
        rd16(3'd2, v);
        chk(req, {16'h0, v}, {16'h0, exp});
    endtask

    task automatic check_flags(input string req, input logic [7:0] exp);
        logic [7:0] v;
        rd(3'd5, v);
        chk(req, {24'h0, v}, {24'h0, exp});
    endtask

    task automatic setup(input logic [15:0] c, input logic [15:0] r, input logic [7:0] ctl);
        wr(3'd4, 8'h00);
        wr(3'd5, 8'h03);
        wr16(3'd0, c);
        wr16(3'd2, r);
        wr(3'd4, ctl);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        for (int a = 0; a < 6; a++) begin
            rd(3'(a), v);
            chk("R1 register reset", {24'h0, v}, 32'h0);
        end
        chk("R1 irq reset", {31'h0, irq}, 32'h0);
        chk("R1 tio_out reset", {31'h0, tio_out}, 32'h0);
        chk("R1 tio_oe reset", {31'h0, tio_oe}, 32'h0);
    endtask

    task automatic t_timer;
        setup(16'd2, 16'd3, 8'h1C);
        repeat (4) @(negedge clk);
        check_cnt("R2 no tick holds", 16'd2);
        ticks(1);
        check_cnt("R2 one tick", 16'd1);
        ticks(1);
        check_cnt("R2 reach zero", 16'd0);
        check_flags("R3 no flag at zero", 8'h00);
        ticks(1);
        check_cnt("R3 reload", 16'd3);
        check_flags("R3 underflow flag", 8'h01);
        chk("R9 irq enabled", {31'h0, irq}, 32'h1);
        wr(3'd5, 8'h01);
        check_flags("R9 write-one clears", 8'h00);
        chk("R9 irq drops", {31'h0, irq}, 32'h0);
        wr(3'd4, 8'h0C);
        ticks(4);
        check_cnt("R3 second reload", 16'd3);
        check_flags("R9 set while disabled", 8'h01);
        chk("R9 irq gated", {31'h0, irq}, 32'h0);
        wr(3'd5, 8'h00);
        check_flags("R9 write-zero keeps", 8'h01);
        wr(3'd5, 8'h01);
        check_flags("R9 cleared", 8'h00);
    endtask

    task automatic t_stop;
        wr(3'd4, 8'h14);
        ticks(3);
        check_cnt("R4 stopped holds", 16'd3);
    endtask

    task automatic t_toggle;
        setup(16'd0, 16'd1, 8'h0D);
        chk("R5 oe in toggle mode", {31'h0, tio_oe}, 32'h1);
        ticks(1);
        check_cnt("R5 reload", 16'd1);
        chk("R5 first toggle", {31'h0, tio_out}, 32'h1);
        ticks(1);
        chk("R5 no toggle without underflow", {31'h0, tio_out}, 32'h1);
        ticks(1);
        chk("R5 second toggle", {31'h0, tio_out}, 32'h0);
        wr(3'd4, 8'h0C);
        chk("R5 oe off in timer mode", {31'h0, tio_oe}, 32'h0);
    endtask

    task automatic t_extcount;
        setup(16'd1, 16'd2, 8'h18);
        ticks(2);
        check_cnt("R6 tick ignored", 16'd1);
        pin(1'b1);
        check_cnt("R6 rising step", 16'd0);
        pin(1'b0);
        check_cnt("R6 falling ignored", 16'd0);
        pin(1'b1);
        check_cnt("R3 edge underflow reload", 16'd2);
        check_flags("R3 edge underflow flag", 8'h01);
        wr(3'd4, 8'h19);
        pin(1'b0);
        check_cnt("R6 falling step", 16'd1);
        pin(1'b1);
        check_cnt("R6 rising ignored", 16'd1);
    endtask

    task automatic t_capture;
        wr(3'd4, 8'h00);
        pin(1'b0);
        setup(16'd5, 16'd0, 8'h2E);
        ticks(2);
        check_cnt("R7 tick count", 16'd3);
        pin(1'b1);
        check_rld("R7 rising capture", 16'd3);
        check_flags("R7 capture flag", 8'h02);
        chk("R7 capture irq", {31'h0, irq}, 32'h1);
        pin(1'b0);
        check_rld("R7 falling ignored", 16'd3);
        ticks(4);
        check_cnt("R7 wrap", 16'hFFFF);
        check_flags("R7 no underflow flag", 8'h02);
        wr(3'd5, 8'h02);
        wr(3'd4, 8'h2F);
        pin(1'b1);
        check_rld("R7 rising ignored", 16'd3);
        check_flags("R7 no flag on wrong edge", 8'h00);
        pin(1'b0);
        check_rld("R7 falling capture", 16'hFFFF);
        check_flags("R7 flag on falling", 8'h02);
    endtask

    task automatic t_illegal;
        setup(16'd1, 16'd5, 8'h3A);
        ticks(3);
        pin(1'b1);
        pin(1'b0);
        check_cnt("R8 count holds", 16'd1);
        check_rld("R8 companion holds", 16'd5);
        check_flags("R8 no flags", 8'h00);
        chk("R8 no irq", {31'h0, irq}, 32'h0);
        wr(3'd4, 8'h3B);
        ticks(2);
        check_cnt("R8 other code holds", 16'd1);
    endtask

    task automatic t_bytes;
        logic [7:0] v;
        wr(3'd4, 8'h00);
        wr(3'd1, 8'hAB);
        check_cnt("R10 high byte only", 16'hAB01);
        wr(3'd2, 8'h5C);
        check_rld("R10 low byte only", 16'h005C);
        wr(3'd4, 8'hEA);
        rd(3'd4, v);
        chk("R11 control readback", {24'h0, v}, 32'h2A);
        rd(3'd6, v);
        chk("R10 unmapped reads zero", {24'h0, v}, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_timer();
        t_stop();
        t_toggle();
        t_extcount();
        t_capture();
        t_illegal();
        t_bytes();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule